// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave (256 bytes)

This block is a synthesizable 256-byte non-volatile memory model that answers as a slave on a two-wire serial bus (SCL clock, SDA data). A fast system clock oversamples both bus lines through a short synchronizer. The block never drives SDA high: it only asserts an open-drain enable that pulls the line low. Three strap inputs form the low part of its 7-bit device address, so up to eight such devices can share one bus.

A master can write one byte or a burst of up to 16 bytes within a 16-byte page. It can read the byte at the internal address counter, load that counter with a dummy write and then read (random read), or stream successive bytes for as long as it keeps acknowledging. A write is held in a page buffer and reaches the array only after a STOP, at the end of an internal program cycle of `PROG_CYCLES` system clocks. During that cycle the device ignores its own address. Both sides are paced by the bus clock itself, so there is no valid/ready handshake at the block's edge. Strap and reset pins are plain levels. The array can be preloaded at reset with a computed pattern for test.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: The device answers only when the first byte after a START holds the 7-bit address 1010 followed by `dev_sel_i[2]`, `dev_sel_i[1]`, `dev_sel_i[0]`, most significant bit first; bit 0 of that byte selects the direction (0 write, 1 read). Any other address gets no acknowledge, and the device stays silent until the next START.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START at any point, even in the middle of a byte, releases SDA and restarts address reception.
- R3: For each byte the device accepts, it pulls SDA low during the ninth SCL clock. It changes its SDA drive only while SCL is low.
- R4: A byte write (START, address+write, word address, one data byte, STOP) stores the data at the word address once the program cycle ends.
- R5: In a page write, each data byte goes to the current address, and then only the low 4 address bits increment (wrapping within the 16-byte page). The address counter keeps that post-increment value afterwards.
- R6: After a STOP that ends a write carrying at least one data byte, a program cycle of exactly `PROG_CYCLES` system clocks runs. During it the device never drives SDA and does not acknowledge its address.
- R7: Data written in a transaction reaches the array only if that transaction ends with a STOP. A repeated START discards it, and no program cycle starts.
- R8: A read with no word address (current-address read) returns the byte at the internal address counter. Each transmitted byte increments the full 8-bit counter, wrapping from 0xFF to 0x00.
- R9: A random read (address+write, word address, repeated START, address+read) returns the byte at that word address.
- R10: While the master acknowledges, the device sends successive bytes. After a not-acknowledge it releases SDA and stays silent until STOP or START.
- R11: After reset SDA is released, the address counter is 0, and with `PRELOAD`=1 every byte i holds i XOR 0xA5 (otherwise 0x00).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND result) |
| dev_sel_i | input | 3 | Strap bits forming the low three address bits |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bench builds the block with `PROG_CYCLES`=600 and `PRELOAD`=1, and straps it to address 1010101. The short program cycle lets a write, a busy-period rejection and the commit all fit within a few thousand clocks. The known preload pattern means every unwritten location has a predictable value, so page wrap, discarded writes and address-counter wrap past 0xFF can be observed as exact data on reads. The bus runs at 40 system clocks per bit, well above the synchronizer and edge-detect latency.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_TX,
    ST_RACK,
    ST_IGNORE
  } bus_state_t;

  // Test pattern loaded at reset when preloading is enabled.
  function automatic logic [7:0] preload_byte(input int unsigned idx);
    return 8'(idx) ^ 8'hA5;
  endfunction

endpackage

// File: rtl/eeprom_line_sync.sv
module eeprom_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
  parameter int PAGE_AW     = 4,
  parameter int PROG_CYCLES = 750000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic                         wr_en,
  input  logic [PAGE_AW-1:0]           wr_off,
  input  logic [7:0]                   wr_data,
  input  logic                         launch,
  output logic                         busy,
  output logic                         commit,
  output logic [(1<<PAGE_AW)*8-1:0]    page_data,
  output logic [(1<<PAGE_AW)-1:0]      page_mask
);

  localparam int PAGE = 1 << PAGE_AW;
  localparam int CW   = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(PROG_CYCLES - 1);

  logic [7:0]    ent [PAGE];
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE; i++) ent[i] <= 8'h00;
    end else if (wr_en) begin
      ent[wr_off] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_mask <= '0;
    end else if (commit || (clear && !busy)) begin
      page_mask <= '0;
    end else if (wr_en) begin
      page_mask[wr_off] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      commit <= 1'b0;
      cnt    <= '0;
    end else begin
      commit <= 1'b0;
      if (!busy) begin
        if (launch && (|page_mask)) begin
          busy <= 1'b1;
          cnt  <= '0;
        end
      end else if (cnt == LAST) begin
        busy   <= 1'b0;
        commit <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  generate
    for (genvar g = 0; g < PAGE; g++) begin : g_flat
      assign page_data[g*8 +: 8] = ent[g];
    end
  endgenerate

endmodule

// File: rtl/eeprom_store.sv
module eeprom_store
  import eeprom_pkg::*;
#(
  parameter int AW      = 8,
  parameter int PAGE_AW = 4,
  parameter bit PRELOAD = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [AW-1:0]               rd_addr,
  output logic [7:0]                  rd_data,
  input  logic                        commit,
  input  logic [AW-PAGE_AW-1:0]       page_base,
  input  logic [(1<<PAGE_AW)*8-1:0]   page_data,
  input  logic [(1<<PAGE_AW)-1:0]     page_mask
);

  localparam int DEPTH = 1 << AW;
  localparam int PAGE  = 1 << PAGE_AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= PRELOAD ? preload_byte(i) : 8'h00;
    end else if (commit) begin
      for (int j = 0; j < PAGE; j++)
        if (page_mask[j])
          mem[{page_base, PAGE_AW'(j)}] <= page_data[j*8 +: 8];
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import eeprom_pkg::*;
#(
  parameter int AW          = 8,
  parameter int PAGE_AW     = 4,
  parameter int PROG_CYCLES = 750000,
  parameter int SYNC_STAGES = 2,
  parameter bit PRELOAD     = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_sel_i,
  output logic       sda_oe_o
);

  localparam int PAGE  = 1 << PAGE_AW;
  localparam int HI_W  = AW - PAGE_AW;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, commit;
  logic [PAGE*8-1:0]  page_data;
  logic [PAGE-1:0]    page_mask;

  bus_state_t        st;
  logic [7:0]        shreg;
  logic [7:0]        txsh;
  logic [3:0]        bitcnt;
  logic [AW-1:0]     addr_q;
  logic [HI_W-1:0]   page_base_q;
  logic              is_read;
  logic              master_ack;
  logic              byte_done;
  logic              buf_wr;
  logic [7:0]        rd_data;

  eeprom_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign byte_done = scl_fall && (bitcnt == 4'd8);
  assign buf_wr    = (st == ST_WDATA) && byte_done && !start_det && !stop_det;

  eeprom_page_buf #(.PAGE_AW(PAGE_AW), .PROG_CYCLES(PROG_CYCLES)) u_pbuf (
    .clk(clk), .rst_n(rst_n), .clear(start_det), .wr_en(buf_wr),
    .wr_off(addr_q[PAGE_AW-1:0]), .wr_data(shreg), .launch(stop_det),
    .busy(busy), .commit(commit), .page_data(page_data), .page_mask(page_mask)
  );

  eeprom_store #(.AW(AW), .PAGE_AW(PAGE_AW), .PRELOAD(PRELOAD)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_addr(addr_q), .rd_data(rd_data),
    .commit(commit), .page_base(page_base_q), .page_data(page_data),
    .page_mask(page_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      shreg       <= 8'h00;
      txsh        <= 8'h00;
      bitcnt      <= 4'd0;
      addr_q      <= '0;
      page_base_q <= '0;
      is_read     <= 1'b0;
      master_ack  <= 1'b0;
      sda_oe_o    <= 1'b0;
    end else if (start_det) begin
      st       <= ST_DEV;
      bitcnt   <= 4'd0;
      sda_oe_o <= 1'b0;
    end else if (stop_det) begin
      st       <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else begin
      case (st)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            bitcnt <= 4'd0;
            if (st == ST_DEV) begin
              if (shreg[7:1] == {DEV_TYPE, dev_sel_i} && !busy) begin
                is_read  <= shreg[0];
                sda_oe_o <= 1'b1;
                st       <= ST_DEV_ACK;
              end else begin
                st <= ST_IGNORE;
              end
            end else if (st == ST_WADDR) begin
              addr_q      <= shreg[AW-1:0];
              page_base_q <= shreg[AW-1:PAGE_AW];
              sda_oe_o    <= 1'b1;
              st          <= ST_WADDR_ACK;
            end else begin
              addr_q   <= {addr_q[AW-1:PAGE_AW], addr_q[PAGE_AW-1:0] + 1'b1};
              sda_oe_o <= 1'b1;
              st       <= ST_WDATA_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            if (is_read) begin
              txsh     <= rd_data;
              sda_oe_o <= ~rd_data[7];
              st       <= ST_TX;
            end else begin
              sda_oe_o <= 1'b0;
              st       <= ST_WADDR;
            end
          end
        end
        ST_WADDR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            sda_oe_o <= 1'b0;
            st       <= ST_WDATA;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            bitcnt   <= 4'd0;
            sda_oe_o <= 1'b0;
            addr_q   <= addr_q + 1'b1;
            st       <= ST_RACK;
          end else if (scl_fall) begin
            txsh     <= {txsh[6:0], 1'b0};
            sda_oe_o <= ~txsh[6];
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            master_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (master_ack) begin
              txsh     <= rd_data;
              sda_oe_o <= ~rd_data[7];
              st       <= ST_TX;
            end else begin
              st <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/eeprom_i2c_checker.sv
module eeprom_i2c_checker #(
  parameter int PROG_CYCLES = 750000
) (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic scl_s,
  input logic start_det,
  input logic busy,
  input logic commit
);

  localparam int CW = $clog2(PROG_CYCLES + 2);

  logic [CW-1:0] busy_len;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  // R6: silent on the bus for the whole program cycle
  p_silent_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  // R6: program cycle lasts exactly PROG_CYCLES clocks
  p_busy_length_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == CW'(PROG_CYCLES)));

  // R2: a START releases the line
  p_start_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  // R3: the device starts pulling SDA only while SCL is low
  p_drive_low_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R7: the array is written only as the program cycle closes
  p_commit_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ($past(busy) && !busy));

endmodule

bind eeprom_i2c_slave eeprom_i2c_checker #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .scl_s(scl_s),
  .start_det(start_det), .busy(busy), .commit(commit)
);

// File: tb/sim_eeprom_i2c_slave.sv
`timescale 1ns/1ps
module sim_eeprom_i2c_slave;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 10;
  localparam int PROG       = 600;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = 8'hAA;
  localparam logic [7:0] DEV_R = 8'hAB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic quiet_chk = 1'b0;
  logic done = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;

  logic [7:0] mem_m [256];
  int addr_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  eeprom_i2c_slave #(.PROG_CYCLES(PROG), .PRELOAD(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .dev_sel_i(STRAP), .sda_oe_o(sda_oe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R6: silent during the program cycle, checked every clock
  always @(negedge clk) begin
    if (quiet_chk) chk("R6 quiet during program cycle", int'(sda_oe), 0);
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_clk(QTR);
    m_scl = 1'b1; wait_clk(QTR);
    m_sda = 1'b0; wait_clk(QTR);
    m_scl = 1'b0; wait_clk(QTR);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_clk(QTR);
    m_scl = 1'b1; wait_clk(QTR);
    m_sda = 1'b1; wait_clk(QTR);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b;    wait_clk(QTR);
    m_scl = 1'b1; wait_clk(2*QTR);
    m_scl = 1'b0; wait_clk(QTR);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; wait_clk(QTR);
    m_scl = 1'b1; wait_clk(QTR);
    b = sda_line; wait_clk(QTR);
    m_scl = 1'b0; wait_clk(QTR);
  endtask

  task automatic tx_byte(input logic [7:0] v, input int exp_ack, input string tag);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    chk(tag, int'(!b), exp_ack);
  endtask

  task automatic rx_byte(input int exp, input logic ack, input string tag);
    logic [7:0] v;
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    m_sda = !ack; wait_clk(QTR);
    m_scl = 1'b1; wait_clk(QTR);
    chk({tag, " released in master ack slot"}, int'(sda_oe), 0);
    wait_clk(QTR);
    m_scl = 1'b0; wait_clk(QTR);
    chk(tag, int'(v), exp);
  endtask

  // reads n bytes from the model address, acking all but the last
  task automatic read_run(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      rx_byte(int'(mem_m[addr_m]), k != n-1, tag);
      addr_m = (addr_m + 1) % 256;
    end
  endtask

  task automatic set_addr(input logic [7:0] a, input string tag);
    bus_start();
    tx_byte(DEV_W, 1, tag);
    tx_byte(a, 1, tag);
    addr_m = a;
  endtask

  task automatic program_wait();
    quiet_chk = 1'b1;
    wait_clk(PROG + 40);
    quiet_chk = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem_m[i] = 8'(i) ^ 8'hA5;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    chk("R11 SDA released after reset", int'(sda_oe), 0);

    // R8 R11: current-address read straight after reset
    bus_start();
    tx_byte(DEV_R, 1, "R1 read address ack");
    read_run(1, "R11 preload via current read at 0");
    bus_stop();

    // R1: foreign address is ignored, also for following bytes
    bus_start();
    tx_byte(8'hA4, 0, "R1 foreign address no ack");
    tx_byte(8'h55, 0, "R1 silent after foreign address");
    bus_stop();

    // R4: byte write; R6: busy device rejects its address
    set_addr(8'h20, "R4 byte write setup");
    tx_byte(8'h3C, 1, "R4 data ack");
    bus_stop();
    bus_start();
    tx_byte(DEV_W, 0, "R6 no ack during program cycle");
    bus_stop();
    program_wait();
    mem_m[8'h20] = 8'h3C;

    // R9: random read back
    set_addr(8'h20, "R9 dummy write");
    bus_start();
    tx_byte(DEV_R, 1, "R9 read address ack");
    read_run(1, "R9 R4 random read of written byte");
    bus_stop();

    // R5: page write wrapping inside the page
    set_addr(8'h4E, "R5 page write setup");
    tx_byte(8'h11, 1, "R5 page byte 0");
    tx_byte(8'h22, 1, "R5 page byte 1");
    tx_byte(8'h33, 1, "R5 page byte 2");
    tx_byte(8'h44, 1, "R5 page byte 3");
    bus_stop();
    program_wait();
    mem_m[8'h4E] = 8'h11; mem_m[8'h4F] = 8'h22;
    mem_m[8'h40] = 8'h33; mem_m[8'h41] = 8'h44;
    addr_m = 8'h42;

    // R5 R8: counter kept its wrapped value
    bus_start();
    tx_byte(DEV_R, 1, "R8 read address ack");
    read_run(1, "R5 R8 current read after page write");
    bus_stop();

    // R10: sequential read across written and preload data
    set_addr(8'h40, "R10 seq setup");
    bus_start();
    tx_byte(DEV_R, 1, "R10 read address ack");
    read_run(4, "R10 sequential read");
    bus_stop();
    set_addr(8'h4E, "R5 wrap check setup");
    bus_start();
    tx_byte(DEV_R, 1, "R5 read address ack");
    read_run(2, "R5 wrapped page data");
    bus_stop();

    // R7: repeated START discards the write
    set_addr(8'h60, "R7 aborted write setup");
    tx_byte(8'h77, 1, "R7 data ack");
    addr_m = 8'h61;
    bus_start();
    tx_byte(DEV_R, 1, "R7 repeated start read ack");
    read_run(1, "R7 read after abort");
    bus_stop();
    set_addr(8'h60, "R7 no program cycle after abort");
    bus_start();
    tx_byte(DEV_R, 1, "R7 read address ack");
    read_run(1, "R7 discarded data not stored");
    bus_stop();

    // R8: counter wraps past 0xFF
    set_addr(8'hFE, "R8 wrap setup");
    bus_start();
    tx_byte(DEV_R, 1, "R8 read address ack");
    read_run(3, "R8 sequential wrap");
    bus_stop();
    bus_start();
    tx_byte(DEV_R, 1, "R8 read address ack after wrap");
    read_run(1, "R8 current read after wrap");
    bus_stop();

    // R2: START in the middle of an address byte restarts reception
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    tx_byte(DEV_R, 1, "R2 restart mid byte ack");
    read_run(1, "R2 read after restart");
    bus_stop();
    wait_clk(20);
    chk("R10 released after final stop", int'(sda_oe), 0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule